// File: doc/BRIEF.md
# Masked Vector Register Move Unit

This block carries out the vector move instruction of a small vertex shader core. On a start strobe it latches a 32-bit instruction word and decodes its fields. It then fetches the operand descriptor that the instruction names and reads a four-component source vector from the input attribute file. Each component is a 24-bit float.

The source vector passes through a per-lane component selector and an optional sign flip, both taken from the descriptor. The result goes into one temporary register, lane by lane, under a 4-bit write mask that is also held in the descriptor.

Software-side logic fills the descriptor store and the attribute file through two simple write ports. The temporary file can be read through a combinational read port. An encoding that this unit cannot execute performs no write and raises an error flag that stays set until reset.

Top module: `vmov_unit`

## Requirements
- R1: While reset is low and after it is released, every temporary register reads zero, every descriptor and attribute entry is zero, and `done` and `err` are low.
- R2: A start accepted on a rising edge (start high while no move is executing) causes the temporary write on the following edge, and `done` is high in the cycle after that write.
- R3: Each result component j (lane j at bits j*24+23 down to j*24) takes the source component whose number sits in descriptor bits [6+2*(3-j) : 5+2*(3-j)], so descriptor bits 12:11 select the source of component 0 and bits 6:5 select the source of component 3.
- R4: When descriptor bit 4 is set, bit 23 (the sign) of every selected component is inverted before the write; when it is clear the components pass unchanged.
- R5: Descriptor bits 3:0 form the write mask, and mask bit i enables component 3-i. Components whose mask bit is clear keep their old value, and a mask of zero leaves the register unchanged.
- R6: Instruction bits 6:0 pick one of 128 descriptors, bits 18:12 give the source (0 to 15 select attribute 0 to 15), and bits 25:21 give the destination (0x10 to 0x1F select temporary 0 to 15).
- R7: An opcode other than 0x13 in bits 31:26, a nonzero value in bits 20:19, a source of 16 or above, or a destination below 0x10 causes no register write and sets `err`. `done` still pulses for such an instruction.
- R8: Once set, `err` stays high through later legal moves until reset.
- R9: A start that arrives while a move is executing is ignored.
- R10: `done` is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_we | input | 1 | Descriptor store write enable |
| desc_addr | input | 7 | Descriptor store write address |
| desc_wdata | input | 13 | Descriptor word (mask 3:0, negate 4, selector 12:5) |
| attr_we | input | 1 | Attribute file write enable |
| attr_addr | input | 4 | Attribute file write address |
| attr_wdata | input | 96 | Attribute vector, component j at bits j*24 upward |
| start | input | 1 | Begin executing `instr` |
| instr | input | 32 | Instruction word |
| done | output | 1 | One-cycle pulse after the move has completed |
| err | output | 1 | Sticky unsupported-encoding flag |
| tmp_raddr | input | 4 | Temporary file read address |
| tmp_rdata | output | 96 | Temporary register contents |

## Verification
A wrong component selector or a lane-order slip in the mask decode shows up as a wrong component in `tmp_rdata`. It can be seen as soon as the move's `done` pulse arrives, provided the selector fields are not symmetric. A missed illegal encoding shows in two places: `err` stays low in the `done` cycle, and the destination register changes when it should not. A lost sticky bit makes `err` fall on the next legal move. Random descriptors and attribute values make a bit-position error visible within a few moves.

// File: rtl/vmov_pkg.sv
package vmov_pkg;
   localparam int INSTR_W   = 32;
   localparam int OP_LSB    = 26;
   localparam int OP_W      = 6;
   localparam int DST_LSB   = 21;
   localparam int DST_W     = 5;
   localparam int IDX_LSB   = 19;
   localparam int IDX_W     = 2;
   localparam int SRC_LSB   = 12;
   localparam int SRC_W     = 7;
   localparam int DSEL_LSB  = 0;
   localparam int DSEL_W    = 7;
   localparam logic [OP_W-1:0] OPC_MOVE = 6'h13;

   localparam int MASK_LSB  = 0;
   localparam int NEG_BIT   = 4;
   localparam int SEL_LSB   = 5;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [DST_W-1:0]  dst;
      logic [IDX_W-1:0]  idx;
      logic [SRC_W-1:0]  src;
      logic [DSEL_W-1:0] dsel;
   } move_fields_t;
endpackage

// File: rtl/vmov_decode.sv
module vmov_decode
   import vmov_pkg::*;
#(
   parameter int NUM_ATTR  = 16,
   parameter int TEMP_BASE = 16,
   parameter int NUM_TEMP  = 16
) (
   input  logic [INSTR_W-1:0] instr,
   output move_fields_t       fld,
   output logic               bad
);
   localparam int TEMP_END = TEMP_BASE + NUM_TEMP;

   logic op_bad, idx_bad, src_bad, dst_bad;

   always_comb begin
      fld.op   = instr[OP_LSB   +: OP_W];
      fld.dst  = instr[DST_LSB  +: DST_W];
      fld.idx  = instr[IDX_LSB  +: IDX_W];
      fld.src  = instr[SRC_LSB  +: SRC_W];
      fld.dsel = instr[DSEL_LSB +: DSEL_W];
   end

   assign op_bad  = (fld.op != OPC_MOVE);
   assign idx_bad = (fld.idx != '0);
   assign src_bad = (int'(fld.src) >= NUM_ATTR);
   assign dst_bad = (int'(fld.dst) < TEMP_BASE) || (int'(fld.dst) >= TEMP_END);
   assign bad     = op_bad | idx_bad | src_bad | dst_bad;
endmodule

// File: rtl/vmov_swizzle.sv
module vmov_swizzle #(
   parameter int LANES  = 4,
   parameter int COMP_W = 24,
   parameter int SEL_W  = $clog2(LANES)
) (
   input  logic [LANES*COMP_W-1:0] src_vec,
   input  logic [LANES*SEL_W-1:0]  sel,
   input  logic                    neg,
   output logic [LANES*COMP_W-1:0] out_vec
);
   localparam logic [COMP_W-1:0] SIGN_FLIP = {1'b1, {(COMP_W-1){1'b0}}};

   logic [COMP_W-1:0] comp [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign comp[g] = src_vec[g*COMP_W +: COMP_W];
   end

   // Lane 0 takes its selector from the most significant field.
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [SEL_W-1:0] pick;
      assign pick = sel[(LANES-1-j)*SEL_W +: SEL_W];
      assign out_vec[j*COMP_W +: COMP_W] = comp[pick] ^ (neg ? SIGN_FLIP : '0);
   end
endmodule

// File: rtl/vmov_regfile.sv
module vmov_regfile #(
   parameter int DEPTH = 16,
   parameter int LANES = 4,
   parameter int LW    = 24,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LANES-1:0]      we,
   input  logic [AW-1:0]         waddr,
   input  logic [LANES*LW-1:0]   wdata,
   input  logic [AW-1:0]         raddr,
   output logic [LANES*LW-1:0]   rdata
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we[l]) begin
            mem[waddr] <= wdata[l*LW +: LW];
         end
      end

      assign rdata[l*LW +: LW] = mem[raddr];
   end
endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
   import vmov_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int COMP_W     = 24,
   parameter int DESC_DEPTH = 128,
   parameter int NUM_ATTR   = 16,
   parameter int NUM_TEMP   = 16,
   parameter int TEMP_BASE  = 16,
   parameter int DESC_W     = 13,
   parameter int DESC_AW    = $clog2(DESC_DEPTH),
   parameter int ATTR_AW    = $clog2(NUM_ATTR),
   parameter int TEMP_AW    = $clog2(NUM_TEMP)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    desc_we,
   input  logic [DESC_AW-1:0]      desc_addr,
   input  logic [DESC_W-1:0]       desc_wdata,
   input  logic                    attr_we,
   input  logic [ATTR_AW-1:0]      attr_addr,
   input  logic [LANES*COMP_W-1:0] attr_wdata,
   input  logic                    start,
   input  logic [INSTR_W-1:0]      instr,
   output logic                    done,
   output logic                    err,
   input  logic [TEMP_AW-1:0]      tmp_raddr,
   output logic [LANES*COMP_W-1:0] tmp_rdata
);
   localparam int VEC_W = LANES * COMP_W;
   localparam int SEL_W = $clog2(LANES);

   // Elaboration-time parameter checks
   if (LANES != 4) begin : g_chk_lanes
      $error("vmov_unit: descriptor layout needs LANES == 4");
   end
   if (COMP_W < 2) begin : g_chk_comp
      $error("vmov_unit: COMP_W must be at least 2");
   end
   if (DESC_DEPTH > (1 << DSEL_W) || DESC_DEPTH < 2) begin : g_chk_desc
      $error("vmov_unit: DESC_DEPTH out of range");
   end
   if (DESC_W != SEL_LSB + LANES*SEL_W) begin : g_chk_descw
      $error("vmov_unit: DESC_W does not match descriptor layout");
   end
   if (NUM_ATTR > (1 << SRC_W) || NUM_ATTR < 2) begin : g_chk_attr
      $error("vmov_unit: NUM_ATTR out of range");
   end
   if (TEMP_BASE + NUM_TEMP > (1 << DST_W) || NUM_TEMP < 2) begin : g_chk_temp
      $error("vmov_unit: temporary range exceeds destination field");
   end

   // Execution stage state
   logic               stage_v;
   logic [INSTR_W-1:0] instr_q;
   move_fields_t       fld;
   logic               dec_bad;
   logic               exec_ok;

   logic [DESC_W-1:0]  desc_q;
   logic [VEC_W-1:0]   src_vec;
   logic [VEC_W-1:0]   swz_vec;
   logic [LANES-1:0]   tmp_we;
   logic [TEMP_AW-1:0] tmp_waddr;
   logic [LANES-1:0]   mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_v <= 1'b0;
         instr_q <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= stage_v;
         if (stage_v && dec_bad) err <= 1'b1;
         if (start && !stage_v) begin
            stage_v <= 1'b1;
            instr_q <= instr;
         end else begin
            stage_v <= 1'b0;
         end
      end
   end

   vmov_decode #(
      .NUM_ATTR (NUM_ATTR),
      .TEMP_BASE(TEMP_BASE),
      .NUM_TEMP (NUM_TEMP)
   ) u_dec (
      .instr(instr_q),
      .fld  (fld),
      .bad  (dec_bad)
   );

   assign exec_ok = stage_v & ~dec_bad;

   // Operand descriptor store: one lane holding the whole word
   vmov_regfile #(
      .DEPTH(DESC_DEPTH),
      .LANES(1),
      .LW   (DESC_W),
      .AW   (DESC_AW)
   ) u_desc (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (desc_we),
      .waddr(desc_addr),
      .wdata(desc_wdata),
      .raddr(DESC_AW'(fld.dsel)),
      .rdata(desc_q)
   );

   // Input attribute file
   vmov_regfile #(
      .DEPTH(NUM_ATTR),
      .LANES(LANES),
      .LW   (COMP_W),
      .AW   (ATTR_AW)
   ) u_attr (
      .clk  (clk),
      .rst_n(rst_n),
      .we   ({LANES{attr_we}}),
      .waddr(attr_addr),
      .wdata(attr_wdata),
      .raddr(ATTR_AW'(fld.src)),
      .rdata(src_vec)
   );

   vmov_swizzle #(
      .LANES (LANES),
      .COMP_W(COMP_W),
      .SEL_W (SEL_W)
   ) u_swz (
      .src_vec(src_vec),
      .sel    (desc_q[SEL_LSB +: LANES*SEL_W]),
      .neg    (desc_q[NEG_BIT]),
      .out_vec(swz_vec)
   );

   // Mask bit i drives lane LANES-1-i.
   assign mask = desc_q[MASK_LSB +: LANES];
   for (genvar j = 0; j < LANES; j++) begin : g_we
      assign tmp_we[j] = exec_ok & mask[LANES-1-j];
   end

   assign tmp_waddr = TEMP_AW'(int'(fld.dst) - TEMP_BASE);

   // Temporary register file
   vmov_regfile #(
      .DEPTH(NUM_TEMP),
      .LANES(LANES),
      .LW   (COMP_W),
      .AW   (TEMP_AW)
   ) u_tmp (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (tmp_we),
      .waddr(tmp_waddr),
      .wdata(swz_vec),
      .raddr(tmp_raddr),
      .rdata(tmp_rdata)
   );
endmodule

// File: rtl/vmov_unit_chk.sv
module vmov_unit_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stage_v,
   input logic             bad,
   input logic             done,
   input logic             err,
   input logic [LANES-1:0] wr_lane
);
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stage_v) |=> stage_v);

   assert_done_after_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stage_v |=> done);

   assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stage_v |=> !stage_v);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_write_in_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lane != '0) |-> stage_v);

   assert_no_write_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_v && bad) |-> (wr_lane == '0));

   assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_v && bad) |=> err);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

bind vmov_unit vmov_unit_chk #(.LANES(LANES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .stage_v(stage_v),
   .bad    (dec_bad),
   .done   (done),
   .err    (err),
   .wr_lane(tmp_we)
);

// File: tb/tb_vmov_unit.sv
module tb_vmov_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        desc_we = 1'b0;
   logic [6:0]  desc_addr = '0;
   logic [12:0] desc_wdata = '0;
   logic        attr_we = 1'b0;
   logic [3:0]  attr_addr = '0;
   logic [95:0] attr_wdata = '0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic        done;
   logic        err;
   logic [3:0]  tmp_raddr = '0;
   logic [95:0] tmp_rdata;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [12:0] m_desc [128];
   logic [95:0] m_attr [16];
   logic [95:0] m_tmp  [16];
   bit          m_err;

   always #4 clk = ~clk;

   vmov_unit dut (
      .clk(clk), .rst_n(rst_n),
      .desc_we(desc_we), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
      .attr_we(attr_we), .attr_addr(attr_addr), .attr_wdata(attr_wdata),
      .start(start), .instr(instr), .done(done), .err(err),
      .tmp_raddr(tmp_raddr), .tmp_rdata(tmp_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [95:0] f_move(input logic [95:0] src, input logic [12:0] d, input logic [95:0] old);
      logic [95:0] r = old;
      for (int j = 0; j < 4; j++) begin
         int sel = int'(d[5 + 2*(3-j) +: 2]);
         logic [23:0] c = src[sel*24 +: 24];
         if (d[4]) c[23] = ~c[23];
         if (d[3-j]) r[j*24 +: 24] = c;
      end
      return r;
   endfunction

   function automatic logic [31:0] f_instr(input int op, input int dst, input int idx, input int src, input int dsel, input logic [4:0] fill);
      return {6'(op), 5'(dst), 2'(idx), 7'(src), fill, 7'(dsel)};
   endfunction

   function automatic bit f_legal(input logic [31:0] w);
      return (w[31:26] == 6'h13) && (w[20:19] == 2'd0) && (w[18:12] < 7'd16) && (w[25:21] >= 5'h10);
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 128; i++) m_desc[i] = '0;
      for (int i = 0; i < 16; i++) begin m_attr[i] = '0; m_tmp[i] = '0; end
      m_err = 1'b0;
   endtask

   task automatic write_desc(input int a, input logic [12:0] d);
      @(negedge clk);
      desc_we = 1'b1; desc_addr = 7'(a); desc_wdata = d;
      @(negedge clk);
      desc_we = 1'b0;
      m_desc[a] = d;
   endtask

   task automatic write_attr(input int a, input logic [95:0] v);
      @(negedge clk);
      attr_we = 1'b1; attr_addr = 4'(a); attr_wdata = v;
      @(negedge clk);
      attr_we = 1'b0;
      m_attr[a] = v;
   endtask

   task automatic check_temps(input string req);
      for (int i = 0; i < 16; i++) begin
         tmp_raddr = 4'(i);
         #0.5;
         check(tmp_rdata === m_tmp[i], req, tmp_rdata, m_tmp[i]);
      end
   endtask

   task automatic model_apply(input logic [31:0] w);
      if (f_legal(w)) begin
         int t = int'(w[25:21]) - 16;
         m_tmp[t] = f_move(m_attr[w[15:12]], m_desc[w[6:0]], m_tmp[t]);
      end else begin
         m_err = 1'b1;
      end
   endtask

   // Accepted start at edge k; write at k+1; done high after k+1.
   task automatic run_op(input logic [31:0] w, input string req);
      @(negedge clk);
      start = 1'b1; instr = w;
      @(negedge clk);
      start = 1'b0;
      check(done === 1'b0, "R2 done early", 96'(done), 96'd0);
      @(negedge clk);
      model_apply(w);
      check(done === 1'b1, "R2 done", 96'(done), 96'd1);
      check(err === m_err, "R7/R8 err", 96'(err), 96'(m_err));
      @(negedge clk);
      check(done === 1'b0, "R10 single pulse", 96'(done), 96'd0);
      check_temps(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(done === 1'b0 && err === 1'b0, "R1 reset outputs", {94'd0, done, err}, 96'd0);
      model_clear();
      check_temps("R1 reset temps");
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd2024));
      model_clear();
      do_reset();
      check(err === 1'b0 && done === 1'b0, "R1 after release", {94'd0, done, err}, 96'd0);
      // R1: descriptors and attributes are zero -> move of zero vector keeps zero
      run_op(f_instr(6'h13, 16'h10, 0, 3, 9, 5'd0), "R1 zero stores");

      for (int i = 0; i < 128; i++) write_desc(i, 13'($urandom));
      for (int i = 0; i < 16; i++) write_attr(i, {$urandom, $urandom, $urandom});

      // Random legal moves: R3 R4 R5 R6
      for (int k = 0; k < 120; k++) begin
         run_op(f_instr(6'h13, 16 + int'($urandom % 16), 0, int'($urandom % 16),
                        int'($urandom % 128), 5'($urandom)), "R3/R4/R5/R6 random move");
      end

      // Directed: identity selector, full mask (R3)
      write_desc(0, {8'h1B, 1'b0, 4'hF});
      write_attr(5, {24'h444444, 24'h333333, 24'h222222, 24'h111111});
      run_op(f_instr(6'h13, 16'h10, 0, 5, 0, 5'd0), "R3 identity");
      // Reversal selector: component 0 <- source 3
      write_desc(1, {8'hE4, 1'b0, 4'hF});
      run_op(f_instr(6'h13, 16'h11, 0, 5, 1, 5'd0), "R3 reverse");
      // Mask 8 writes only component 0 (R5)
      write_desc(2, {8'h00, 1'b0, 4'h8});
      run_op(f_instr(6'h13, 16'h12, 0, 5, 2, 5'd0), "R5 mask bit3 lane0");
      // Mask 1 writes only component 3, with negate (R4, R5)
      write_desc(3, {8'hFF, 1'b1, 4'h1});
      run_op(f_instr(6'h13, 16'h12, 0, 5, 3, 5'd0), "R4/R5 negate lane3");
      // Mask 0 leaves register unchanged (R5)
      write_desc(4, {8'h55, 1'b1, 4'h0});
      run_op(f_instr(6'h13, 16'h10, 0, 5, 4, 5'd0), "R5 mask zero");
      // Top descriptor slot and top temporary (R6)
      write_desc(127, {8'h1B, 1'b1, 4'hF});
      write_attr(15, {24'h800001, 24'h7FFFFF, 24'h000000, 24'hABCDEF});
      run_op(f_instr(6'h13, 16'h1F, 0, 15, 127, 5'h1F), "R6 top entries");

      // Start while busy is ignored (R9)
      @(negedge clk);
      start = 1'b1; instr = f_instr(6'h13, 16'h13, 0, 5, 0, 5'd0);
      @(negedge clk);
      instr = f_instr(6'h13, 16'h14, 0, 5, 0, 5'd0);
      @(negedge clk);
      start = 1'b0;
      model_apply(f_instr(6'h13, 16'h13, 0, 5, 0, 5'd0));
      check(done === 1'b1, "R9 done for first", 96'(done), 96'd1);
      @(negedge clk);
      check(done === 1'b0, "R9 no second done", 96'(done), 96'd0);
      check_temps("R9 second start ignored");

      // Unsupported encodings: no write, err set (R7)
      run_op(f_instr(6'h12, 16'h15, 0, 5, 0, 5'd0), "R7 bad opcode");
      run_op(f_instr(6'h13, 16'h15, 1, 5, 0, 5'd0), "R7 index select");
      run_op(f_instr(6'h13, 16'h15, 0, 16, 0, 5'd0), "R7 source 16");
      run_op(f_instr(6'h13, 16'h0F, 0, 5, 0, 5'd0), "R7 dest 0x0F");
      run_op(f_instr(6'h13, 0, 0, 5, 0, 5'd0), "R7 dest 0");
      // Legal move after error: err stays (R8)
      run_op(f_instr(6'h13, 16'h15, 0, 5, 0, 5'd0), "R8 sticky legal move");
      check(err === 1'b1, "R8 err held", 96'(err), 96'd1);

      // Reset clears everything (R1)
      do_reset();
      run_op(f_instr(6'h13, 16'h10, 0, 5, 0, 5'd0), "R1 stores cleared");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule